// File: doc/BRIEF.md
# Indirect Register Access Port

This block is the host-facing front end of a peripheral whose 64 eight-bit internal registers sit behind only four byte addresses. Address 0 is a control location; addresses 1, 2 and 3 reach the three port data registers directly. Any other internal register is reached in two steps. The host first writes a register number to the control location. Its next control access reads or writes that register. The selection persists after the access, so the host can poll one register by reading the control location again and again.

A three-state machine governs the control location. In `ST_HELD` the block is in its soft-reset condition. In `ST_PTR` the next control write is a register number. In `ST_DATA` the next control access reaches the selected register. The transitions are:

- `ST_HELD -> ST_PTR`: a control write with bit 0 clear.
- `ST_PTR -> ST_DATA`: any control write.
- `ST_DATA -> ST_PTR`: a control read, or a control write that does not set the reset bit.
- `ST_DATA -> ST_HELD`: a control write to register 0 with bit 0 set.
- All other cycles hold the state.

The register file behind the machine models counters, ports and interrupt logic as plain storage. A few read-only locations hold fixed values.

Top module: `regbank_host_port`

## Requirements
- R1: After `rst_n` is released, `reset_held` is 1 and `mie_out` is 0. A control read returns 0x01 (register 0). Every writable register other than register 0 reads 0, and each read-only register reads 0x80 OR its index.
- R2: `bus_addr` 0 is the control location. `bus_addr` 1, 2 and 3 read and write internal registers 0x0D, 0x0E and 0x0F directly. `bus_rdata` shows the addressed value in the same cycle while `bus_rd` is high, and is 0 otherwise. A write takes effect at the clock edge and can be read back in the next cycle. A cycle with both `bus_wr` and `bus_rd` high counts as a write.
- R3: In `ST_PTR`, a control write loads the pointer from `bus_wdata[5:0]`, ignores bits 7:6, and moves to `ST_DATA`.
- R4: In `ST_DATA`, a control write stores `bus_wdata` into the selected register and returns to `ST_PTR`.
- R5: A control read returns the selected register. In `ST_DATA` the read moves the machine to `ST_PTR`. In `ST_PTR` the read leaves both the state and the pointer unchanged, so repeated reads keep returning the same register and the next control write is still a pointer.
- R6: Direct accesses at `bus_addr` 1 to 3 change neither the state nor the pointer.
- R7: Registers 0x10 to 0x15 and 0x1F are read-only. Writes to them are ignored, and each reads 0x80 OR its index.
- R8: A write of register 0 with bit 0 set enters `ST_HELD`. Register 0 becomes 0x01, every other writable register returns to 0, and the pointer returns to 0.
- R9: In `ST_HELD`, direct writes and control writes with bit 0 set are ignored. A control write with bit 0 clear stores `bus_wdata` into register 0 and moves to `ST_PTR`.
- R10: `mie_out` equals bit 7 of register 0, and `reset_held` equals bit 0 of register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Byte address: 0 control, 1 to 3 port data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while `bus_rd` is high |
| mie_out | output | 1 | Master interrupt enable (register 0 bit 7) |
| reset_held | output | 1 | Soft-reset condition (register 0 bit 0) |

## Verification
Read data depends only on the address and on register state, so the bench samples `bus_rdata` in the same cycle as the read strobe, 5 ns after it drives the strobe and before the next rising edge. A write, a pointer load or a state change lands on the rising edge inside the access, so `mie_out`, `reset_held` and any read-back are sampled in a later cycle, with at least one idle cycle between accesses. The checks sweep the pointer over every internal register and compute the expected value arithmetically from the index. They also cover polling, direct access placed between a pointer write and its data write, and both entry to and exit from the soft-reset condition.

// File: rtl/rbp_pkg.sv
package rbp_pkg;

    // Control-location sequencing states
    typedef enum logic [1:0] {
        ST_HELD = 2'd0,
        ST_PTR  = 2'd1,
        ST_DATA = 2'd2
    } acc_state_t;

    // Read-only window of the modelled register file
    localparam int RO_LO  = 16;
    localparam int RO_HI  = 21;
    localparam int RO_VEC = 31;

    function automatic bit rb_is_readonly(input int idx);
        return ((idx >= RO_LO) && (idx <= RO_HI)) || (idx == RO_VEC);
    endfunction

endpackage

// File: rtl/rbp_access_fsm.sv
module rbp_access_fsm
    import rbp_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int PTR_W      = 6,
    parameter int RST_BIT    = 0,
    parameter int MASTER_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr_i,
    input  logic              ctrl_rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              held_i,
    output acc_state_t        state_o,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              data_we_o
);

    localparam logic [PTR_W-1:0] MASTER_PTR = PTR_W'(MASTER_IDX);

    acc_state_t       state_q, state_n;
    logic [PTR_W-1:0] ptr_q, ptr_n;
    logic             data_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HELD;
            ptr_q   <= MASTER_PTR;
        end else begin
            state_q <= state_n;
            ptr_q   <= ptr_n;
        end
    end

    always_comb begin
        state_n = state_q;
        ptr_n   = ptr_q;
        data_we = 1'b0;
        unique case (state_q)
            ST_HELD: begin
                if (ctrl_wr_i && !wdata_i[RST_BIT]) begin
                    data_we = 1'b1;
                    state_n = ST_PTR;
                end
            end
            ST_PTR: begin
                if (ctrl_wr_i) begin
                    ptr_n   = wdata_i[PTR_W-1:0];
                    state_n = ST_DATA;
                end
            end
            ST_DATA: begin
                if (ctrl_wr_i) begin
                    data_we = 1'b1;
                    if ((ptr_q == MASTER_PTR) && wdata_i[RST_BIT]) begin
                        state_n = ST_HELD;
                        ptr_n   = MASTER_PTR;
                    end else begin
                        state_n = ST_PTR;
                    end
                end else if (ctrl_rd_i) begin
                    state_n = ST_PTR;
                end
            end
            default: begin
                state_n = ST_HELD;
                ptr_n   = MASTER_PTR;
            end
        endcase
    end

    assign state_o   = state_q;
    assign ptr_o     = ptr_q;
    assign data_we_o = data_we;

    // R8
    held_flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD) == held_i);

    // R3
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PTR && ctrl_wr_i) |=>
        (state_q == ST_DATA && ptr_q == $past(wdata_i[PTR_W-1:0])));

    // R5
    poll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PTR && ctrl_rd_i && !ctrl_wr_i) |=>
        (state_q == ST_PTR && $stable(ptr_q)));

endmodule

// File: rtl/rbp_addr_decode.sv
module rbp_addr_decode #(
    parameter int ADDR_W    = 2,
    parameter int PTR_W     = 6,
    parameter int PORT_BASE = 13
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic              held_i,
    input  logic [PTR_W-1:0]  ptr_i,
    input  logic              fsm_we_i,
    output logic              ctrl_wr_o,
    output logic              ctrl_rd_o,
    output logic              file_we_o,
    output logic [PTR_W-1:0]  idx_o
);

    logic             is_ctrl;
    logic [PTR_W-1:0] direct_idx;

    always_comb begin
        is_ctrl    = (addr_i == '0);
        direct_idx = PTR_W'(PORT_BASE + int'(addr_i) - 1);
        ctrl_wr_o  = wr_i && is_ctrl;
        ctrl_rd_o  = rd_i && !wr_i && is_ctrl;
        file_we_o  = fsm_we_i || (wr_i && !is_ctrl && !held_i);
        idx_o      = is_ctrl ? ptr_i : direct_idx;
    end

endmodule

// File: rtl/rbp_reg_file.sv
module rbp_reg_file
    import rbp_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int NUM_REGS   = 64,
    parameter int PTR_W      = 6,
    parameter int RST_BIT    = 0,
    parameter int MASTER_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [PTR_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] master_o
);

    localparam logic [DATA_W-1:0] MASTER_RV = DATA_W'(1) << RST_BIT;
    localparam logic [DATA_W-1:0] RO_MARK   = DATA_W'(1) << (DATA_W - 1);

    logic [NUM_REGS*DATA_W-1:0] flat;
    logic                       enter_rst;

    assign enter_rst = we_i && (idx_i == PTR_W'(MASTER_IDX)) && wdata_i[RST_BIT];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (rb_is_readonly(i)) begin : g_ro
            assign flat[i*DATA_W +: DATA_W] = RO_MARK | DATA_W'(i);
        end else if (i == MASTER_IDX) begin : g_master
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= MASTER_RV;
                else if (we_i && idx_i == PTR_W'(i))
                    q <= wdata_i[RST_BIT] ? MASTER_RV : wdata_i;
            end
            assign flat[i*DATA_W +: DATA_W] = q;
        end else begin : g_rw
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= '0;
                else if (enter_rst)
                    q <= '0;
                else if (we_i && idx_i == PTR_W'(i))
                    q <= wdata_i;
            end
            assign flat[i*DATA_W +: DATA_W] = q;
        end
    end

    assign rdata_o  = flat[int'(idx_i)*DATA_W +: DATA_W];
    assign master_o = flat[MASTER_IDX*DATA_W +: DATA_W];

    // R8
    soft_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter_rst |=> (master_o == MASTER_RV &&
                       flat[(MASTER_IDX+1)*DATA_W +: DATA_W] == '0));

endmodule

// File: rtl/regbank_host_port.sv
module regbank_host_port
    import rbp_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NUM_REGS  = 64,
    parameter int ADDR_W    = 2,
    parameter int PORT_BASE = 13,
    parameter int RST_BIT   = 0,
    parameter int MIE_BIT   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              mie_out,
    output logic              reset_held
);

    localparam int PTR_W      = $clog2(NUM_REGS);
    localparam int MASTER_IDX = 0;

    acc_state_t        state;
    logic [PTR_W-1:0]  ptr;
    logic              fsm_we, ctrl_wr, ctrl_rd, file_we, held;
    logic [PTR_W-1:0]  idx;
    logic [DATA_W-1:0] file_rdata, master;

    assign held = master[RST_BIT];

    rbp_access_fsm #(
        .DATA_W(DATA_W), .PTR_W(PTR_W), .RST_BIT(RST_BIT), .MASTER_IDX(MASTER_IDX)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr), .ctrl_rd_i(ctrl_rd),
        .wdata_i(bus_wdata), .held_i(held), .state_o(state), .ptr_o(ptr),
        .data_we_o(fsm_we)
    );

    rbp_addr_decode #(
        .ADDR_W(ADDR_W), .PTR_W(PTR_W), .PORT_BASE(PORT_BASE)
    ) u_dec (
        .addr_i(bus_addr), .wr_i(bus_wr), .rd_i(bus_rd),
        .held_i(state == ST_HELD), .ptr_i(ptr), .fsm_we_i(fsm_we),
        .ctrl_wr_o(ctrl_wr), .ctrl_rd_o(ctrl_rd), .file_we_o(file_we), .idx_o(idx)
    );

    rbp_reg_file #(
        .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .PTR_W(PTR_W),
        .RST_BIT(RST_BIT), .MASTER_IDX(MASTER_IDX)
    ) u_rf (
        .clk(clk), .rst_n(rst_n), .we_i(file_we), .idx_i(idx), .wdata_i(bus_wdata),
        .rdata_o(file_rdata), .master_o(master)
    );

    assign bus_rdata  = bus_rd ? file_rdata : '0;
    assign mie_out    = master[MIE_BIT];
    assign reset_held = held;

    // R6
    direct_keeps_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && bus_addr != '0) |=> ($stable(ptr) && $stable(state)));

endmodule

// File: tb/sim_regbank_host_port.sv
module sim_regbank_host_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       mie_out, reset_held;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    regbank_host_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mie_out(mie_out), .reset_held(reset_held)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #5 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic bit is_ro(input int i);
        return (i >= 16 && i <= 21) || i == 31;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset_held", {7'd0, reset_held}, 8'h01);
        chk("R1 mie_out", {7'd0, mie_out}, 8'h00);
        rd(2'd0, d); chk("R1 control read after reset", d, 8'h01);
        rd(2'd1, d); chk("R1 port reg after reset", d, 8'h00);
        chk("R2 rdata idle is zero", bus_rdata, 8'h00);

        // R9 release soft reset
        wr(2'd0, 8'h00);
        chk("R9 release", {7'd0, reset_held}, 8'h00);

        // R3 R4 R7 sweep over all registers except 0
        for (int i = 1; i < 64; i++) begin
            v = 8'((i * 7 + 3) & 8'hFF);
            wr(2'd0, 8'(i) | 8'hC0);
            wr(2'd0, v);
            wr(2'd0, 8'(i));
            rd(2'd0, d);
            if (is_ro(i)) chk("R7 read-only hold", d, 8'h80 | 8'(i));
            else          chk("R3 R4 pointer/data write", d, v);
        end
        // R1 check of untouched read-only value through direct ptr already covered; R2 direct read
        rd(2'd1, d); chk("R2 direct A", d, 8'((13 * 7 + 3) & 8'hFF));
        rd(2'd3, d); chk("R2 direct C", d, 8'((15 * 7 + 3) & 8'hFF));

        // R5 persistent polling
        wr(2'd0, 8'd5); wr(2'd0, 8'h3C); wr(2'd0, 8'd5);
        for (int k = 0; k < 4; k++) begin
            rd(2'd0, d); chk("R5 repeated poll", d, 8'h3C);
        end
        wr(2'd0, 8'd6); wr(2'd0, 8'h77);
        wr(2'd0, 8'd5); rd(2'd0, d); chk("R5 write after poll is pointer", d, 8'h3C);
        wr(2'd0, 8'd6); rd(2'd0, d); chk("R5 data landed in reg 6", d, 8'h77);

        // R2 direct writes, read through pointer
        wr(2'd2, 8'hB2);
        wr(2'd0, 8'd14); rd(2'd0, d); chk("R2 direct write B", d, 8'hB2);

        // R6 direct access between pointer write and data write
        wr(2'd0, 8'd9);
        wr(2'd1, 8'hA1);
        rd(2'd3, d);
        wr(2'd0, 8'h5A);
        wr(2'd0, 8'd9); rd(2'd0, d); chk("R6 data still to reg 9", d, 8'h5A);
        rd(2'd1, d); chk("R6 direct write A", d, 8'hA1);

        // R10 master interrupt enable
        wr(2'd0, 8'd0); wr(2'd0, 8'h80);
        chk("R10 mie_out set", {7'd0, mie_out}, 8'h01);
        chk("R10 reset_held clear", {7'd0, reset_held}, 8'h00);

        // R8 soft reset entry
        wr(2'd0, 8'd0); wr(2'd0, 8'h81);
        chk("R8 reset_held", {7'd0, reset_held}, 8'h01);
        chk("R8 mie cleared", {7'd0, mie_out}, 8'h00);
        rd(2'd0, d); chk("R8 control read reg0", d, 8'h01);
        rd(2'd1, d); chk("R8 port A cleared", d, 8'h00);

        // R9 writes ignored while held
        wr(2'd1, 8'h33);
        wr(2'd0, 8'h85);
        rd(2'd1, d); chk("R9 direct write ignored", d, 8'h00);
        chk("R9 set-bit write ignored", {7'd0, mie_out}, 8'h00);
        wr(2'd0, 8'h80);
        chk("R9 release loads reg0", {7'd0, mie_out}, 8'h01);
        chk("R9 release clears held", {7'd0, reset_held}, 8'h00);
        wr(2'd0, 8'd9); rd(2'd0, d); chk("R8 reg 9 cleared", d, 8'h00);
        wr(2'd0, 8'd31); rd(2'd0, d); chk("R7 vector reg after reset", d, 8'h9F);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule